// File: doc/BRIEF.md
# ISA Plug-and-Play Configuration Controller

This block is the configuration engine on a jumperless ISA expansion card that carries three logical devices. It watches the host's I/O write and read strobes, the full 16-bit I/O address and the 8-bit data lines. The card stays deaf to configuration traffic until the host writes a 32-byte unlock key to the shared index port. After that it can join a serial isolation contest against other cards and take a card select number (CSN). With its CSN selected, the host programs each device's I/O base, interrupt number and activate bit.

The per-device registers sit behind one device selector, so the host sees one device at a time. Three shared 8-bit ports carry all configuration traffic: an index port (0x0279), a write-data port (0x0A79) and a read-data port (0x020B). The card drives decoded chip selects for each device from the programmed bases. It routes each device's interrupt request onto the system IRQ line the host chose. Once the host sends the card back to the locked state, the programmed settings keep working but no write can alter them.

Register indices: 0x01 isolation, 0x02 control, 0x03 wake, 0x06 CSN, 0x07 device selector, 0x30 activate, 0x60/0x61 base high/low byte, 0x70 interrupt number.

Top module: `pnp_cfg_ctrl`

## Requirements
- R1: After reset the card is locked with CSN 0. All registers are zero, the read port is not driven, and no chip select or IRQ line is active even when devices request interrupts.
- R2: While locked, index-port writes are compared with the key. The key has 32 bytes: the first is 0x6A and each next byte is the previous one shifted right, with bit1 XOR bit0 of the previous byte as the new bit 7. A wrong byte restarts matching at the first byte. Data-port writes and reads are ignored until the last byte matches, and the card then sleeps.
- R3: A wake write (index 0x03) whose data equals the CSN sends the card to isolation if the CSN is 0, and to configuration otherwise. Any other wake value puts a card that is not locked to sleep.
- R4: In isolation, two reads of the read port at index 0x01 carry one identifier bit, LSB first, over 72 bits. For a 1 the card drives 0x55 on the first read and 0xAA on the second. For a 0 it drives nothing. After 72 bits it drives nothing.
- R5: A card whose current bit is 0 that sees 0x55 and then 0xAA on the bus goes to sleep and stops driving.
- R6: A CSN write (index 0x06) in isolation or configuration stores the value and enters configuration. The value reads back at index 0x06.
- R7: In configuration, index 0x07 selects the device when the written value is below 3. Larger values are ignored. Indices 0x30 (bit 0), 0x60, 0x61 and 0x70 (low nibble) read and write the selected device's own copy.
- R8: A device's chip select is high only during a read or write strobe when it is activated and address bits 15..3 equal its base bits 15..3.
- R9: An activated device that requests an interrupt drives the IRQ line numbered by its interrupt register, but only for 3, 4, 5, 6, 7, 9, 10, 11, 12 or 15. Any other number drives nothing.
- R10: Control write (index 0x02) with bit 1 set relocks the card. Programmed settings stay in force, later data writes change nothing, and only the full key unlocks again.
- R11: The read port is driven only during a read strobe at 0x020B, in configuration (any index, unknown ones read 0) or during isolation as in R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_wr | input | 1 | Host I/O write strobe, one cycle per access |
| io_rd | input | 1 | Host I/O read strobe, one cycle per access |
| io_addr | input | 16 | Host I/O address |
| io_wdata | input | 8 | Host write data |
| io_bus | input | 8 | Value seen on the shared data lines during a read |
| io_rdata | output | 8 | Data the card drives on a read |
| io_rdata_oe | output | 1 | Card drives io_rdata onto the bus |
| dev_irq | input | 3 | Interrupt requests from the three devices |
| dev_cs | output | 3 | Decoded chip select per device |
| irq_line | output | 16 | System IRQ lines 0..15 |

## Verification
Every cycle the assertions check the things that need no history. The read port is driven only on a read-data access and never while locked. Isolation output is always one of the two pattern bytes. Chip selects need a strobe, and no IRQ outside the legal set is ever driven. They also check that the key unlock, the CSN grant and a drop to sleep each follow the host access that causes them. Only the bench's scenarios can show the sequences that span many accesses, checked against a behavioural model on every clock: key restart after a wrong byte, winning and losing isolation bit by bit, per-device banking, full 16-bit decode, and settings that survive relock untouched.

// File: rtl/pnp_cfg_ctrl.sv
module pnp_cfg_ctrl #(
  parameter logic [15:0] IDX_PORT = 16'h0279,
  parameter logic [15:0] WR_PORT  = 16'h0A79,
  parameter logic [15:0] RD_PORT  = 16'h020B,
  parameter int NDEV = 3,
  parameter int ID_BITS = 72,
  parameter logic [ID_BITS-1:0] SERIAL_ID = 72'hA5_0123_4567_89AB_CDEF,
  parameter int SPAN_LOG2 = 3,
  parameter int KEY_LEN = 32,
  parameter logic [7:0] KEY_SEED = 8'h6A
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        io_wr,
  input  logic        io_rd,
  input  logic [15:0] io_addr,
  input  logic [7:0]  io_wdata,
  input  logic [7:0]  io_bus,
  output logic [7:0]  io_rdata,
  output logic        io_rdata_oe,
  input  logic [NDEV-1:0] dev_irq,
  output logic [NDEV-1:0] dev_cs,
  output logic [15:0] irq_line
);
  localparam int KIW = $clog2(KEY_LEN);
  localparam int BW  = $clog2(ID_BITS + 1);
  localparam int LW  = (NDEV > 1) ? $clog2(NDEV) : 1;
  localparam logic [KIW-1:0] KLAST = KIW'(KEY_LEN - 1);
  localparam logic [BW-1:0]  IDEND = BW'(ID_BITS);
  localparam logic [7:0]     NDEV8 = 8'(NDEV);
  localparam logic [15:0]    IRQ_OK = 16'h9EF8;

  localparam logic [7:0] X_ISO = 8'h01, X_CTL = 8'h02, X_WAKE = 8'h03, X_CSN = 8'h06,
                         X_LDN = 8'h07, X_ACT = 8'h30, X_BHI = 8'h60, X_BLO = 8'h61,
                         X_IRQ = 8'h70;

  typedef enum logic [1:0] {S_KEY, S_SLEEP, S_ISO, S_CFG} st_t;

  st_t            st;
  logic [7:0]     key_byte, index, csn;
  logic [KIW-1:0] key_cnt;
  logic [LW-1:0]  ldn;
  logic [BW-1:0]  bitp;
  logic           half, saw55;
  logic [15:0]    base [NDEV];
  logic [3:0]     irqn [NDEV];
  logic [NDEV-1:0] act;

  wire wr_idx = io_wr && io_addr == IDX_PORT;
  wire wr_dat = io_wr && io_addr == WR_PORT;
  wire rd_dat = io_rd && io_addr == RD_PORT;
  wire cfg    = st == S_CFG;
  wire id_bit = (bitp < IDEND) ? SERIAL_ID[bitp] : 1'b0;
  wire iso_rd = rd_dat && st == S_ISO && index == X_ISO && bitp < IDEND;
  wire drive  = iso_rd && id_bit;

  assign io_rdata_oe = drive || (rd_dat && cfg);

  always_comb begin
    io_rdata = 8'h00;
    if (drive) io_rdata = half ? 8'hAA : 8'h55;
    else if (rd_dat && cfg)
      case (index)
        X_CSN: io_rdata = csn;
        X_LDN: io_rdata = 8'(ldn);
        X_ACT: io_rdata = {7'd0, act[ldn]};
        X_BHI: io_rdata = base[ldn][15:8];
        X_BLO: io_rdata = base[ldn][7:0];
        X_IRQ: io_rdata = {4'd0, irqn[ldn]};
        default: io_rdata = 8'h00;
      endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_KEY;
      key_byte <= KEY_SEED;
      key_cnt <= '0;
      index <= '0;
      csn <= '0;
      ldn <= '0;
      bitp <= '0;
      half <= 1'b0;
      saw55 <= 1'b0;
      act <= '0;
      for (int d = 0; d < NDEV; d++) begin
        base[d] <= '0;
        irqn[d] <= '0;
      end
    end else if (st == S_KEY) begin
      if (wr_idx) begin
        if (io_wdata == key_byte && key_cnt == KLAST) begin
          st <= S_SLEEP;
          key_cnt <= '0;
          key_byte <= KEY_SEED;
        end else if (io_wdata == key_byte) begin
          key_cnt <= key_cnt + 1'b1;
          key_byte <= {key_byte[1] ^ key_byte[0], key_byte[7:1]};
        end else begin
          key_cnt <= '0;
          key_byte <= KEY_SEED;
        end
      end
    end else begin
      if (wr_idx) index <= io_wdata;
      if (wr_dat)
        case (index)
          X_CTL: if (io_wdata[1]) st <= S_KEY;
          X_WAKE:
            if (io_wdata == csn) begin
              st <= (csn == 8'd0) ? S_ISO : S_CFG;
              bitp <= '0;
              half <= 1'b0;
              saw55 <= 1'b0;
            end else st <= S_SLEEP;
          X_CSN:
            if (st == S_ISO || cfg) begin
              csn <= io_wdata;
              st <= S_CFG;
            end
          X_LDN: if (cfg && io_wdata < NDEV8) ldn <= io_wdata[LW-1:0];
          X_ACT: if (cfg) act[ldn] <= io_wdata[0];
          X_BHI: if (cfg) base[ldn][15:8] <= io_wdata;
          X_BLO: if (cfg) base[ldn][7:0] <= io_wdata;
          X_IRQ: if (cfg) irqn[ldn] <= io_wdata[3:0];
          default: ;
        endcase
      if (iso_rd) begin
        if (!half) begin
          half <= 1'b1;
          saw55 <= io_bus == 8'h55;
        end else begin
          half <= 1'b0;
          bitp <= bitp + 1'b1;
          if (!id_bit && saw55 && io_bus == 8'hAA) st <= S_SLEEP;
        end
      end
    end
  end

  for (genvar d = 0; d < NDEV; d++) begin : g_cs
    assign dev_cs[d] = act[d] && (io_rd || io_wr) &&
                       io_addr[15:SPAN_LOG2] == base[d][15:SPAN_LOG2];
  end

  always_comb begin
    irq_line = '0;
    for (int d = 0; d < NDEV; d++)
      if (act[d] && dev_irq[d] && IRQ_OK[irqn[d]]) irq_line[irqn[d]] = 1'b1;
  end
endmodule

module pnp_cfg_ctrl_chk #(
  parameter logic [15:0] IDX_PORT = 16'h0279,
  parameter logic [15:0] WR_PORT  = 16'h0A79,
  parameter logic [15:0] RD_PORT  = 16'h020B,
  parameter int NDEV = 3
)(
  input logic        clk,
  input logic        rst_n,
  input logic        io_wr,
  input logic        io_rd,
  input logic [15:0] io_addr,
  input logic [7:0]  io_rdata,
  input logic        io_rdata_oe,
  input logic [NDEV-1:0] dev_cs,
  input logic [15:0] irq_line,
  input logic [1:0]  st
);
  localparam logic [1:0] C_KEY = 2'd0, C_SLEEP = 2'd1, C_ISO = 2'd2, C_CFG = 2'd3;

  // R11
  oe_on_read_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_rdata_oe |-> io_rd && io_addr == RD_PORT);
  // R2
  locked_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == C_KEY |-> !io_rdata_oe);
  // R4
  iso_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rdata_oe && st == C_ISO) |-> (io_rdata == 8'h55 || io_rdata == 8'hAA));
  // R8
  cs_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|dev_cs) |-> (io_rd || io_wr));
  // R9
  irq_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_line & ~16'h9EF8) == 16'h0000);
  // R2
  unlock_by_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_SLEEP && $past(st) == C_KEY) |-> $past(io_wr && io_addr == IDX_PORT));
  // R6
  csn_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_CFG && $past(st) == C_ISO) |-> $past(io_wr && io_addr == WR_PORT));
  // R5
  iso_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_SLEEP && $past(st) == C_ISO) |->
      $past((io_rd && io_addr == RD_PORT) || (io_wr && io_addr == WR_PORT)));
endmodule

bind pnp_cfg_ctrl pnp_cfg_ctrl_chk #(
  .IDX_PORT(IDX_PORT), .WR_PORT(WR_PORT), .RD_PORT(RD_PORT), .NDEV(NDEV)
) u_chk (
  .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
  .io_rdata(io_rdata), .io_rdata_oe(io_rdata_oe), .dev_cs(dev_cs),
  .irq_line(irq_line), .st(st)
);

// File: tb/test_pnp_cfg_ctrl.sv
module test_pnp_cfg_ctrl;
  localparam logic [71:0] ID = 72'hA5_0123_4567_89AB_CDEF;
  localparam logic [15:0] IDXP = 16'h0279, WRP = 16'h0A79, RDP = 16'h020B;

  logic clk = 0, rst_n = 0, io_wr = 0, io_rd = 0;
  logic [15:0] io_addr = 0;
  logic [7:0] io_wdata = 0, io_bus, io_rdata;
  logic io_rdata_oe;
  logic [2:0] dev_irq = 0, dev_cs;
  logic [15:0] irq_line;
  logic rival_on = 0;
  logic [7:0] rival_val = 0;

  assign io_bus = rival_on ? rival_val : (io_rdata_oe ? io_rdata : 8'hFF);

  pnp_cfg_ctrl #(.SERIAL_ID(ID)) i_pnp_cfg_ctrl (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_bus(io_bus), .io_rdata(io_rdata),
    .io_rdata_oe(io_rdata_oe), .dev_irq(dev_irq), .dev_cs(dev_cs), .irq_line(irq_line)
  );

  always #10 clk = ~clk;

  int errors = 0, checks = 0;
  logic [7:0] key [32];

  // behavioural reference: 0 locked, 1 sleep, 2 isolation, 3 config
  int m_st = 0, m_kc = 0, m_bitp = 0, m_ldn = 0;
  logic [7:0] m_idx = 0, m_csn = 0;
  bit m_half = 0, m_saw = 0;
  logic [15:0] m_base [3] = '{default: 16'h0};
  logic [3:0]  m_irq  [3] = '{default: 4'h0};
  bit          m_act  [3] = '{default: 1'b0};

  function automatic bit rd_port();
    return io_rd && io_addr == RDP;
  endfunction

  function automatic bit exp_oe();
    if (m_st == 2 && m_idx == 8'h01 && rd_port() && m_bitp < 72) return ID[m_bitp];
    return m_st == 3 && rd_port();
  endfunction

  function automatic logic [7:0] exp_data();
    if (m_st == 2) return m_half ? 8'hAA : 8'h55;
    case (m_idx)
      8'h06: return m_csn;
      8'h07: return 8'(m_ldn);
      8'h30: return {7'd0, m_act[m_ldn]};
      8'h60: return m_base[m_ldn][15:8];
      8'h61: return m_base[m_ldn][7:0];
      8'h70: return {4'd0, m_irq[m_ldn]};
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [2:0] exp_cs();
    logic [2:0] r = 0;
    for (int d = 0; d < 3; d++)
      r[d] = m_act[d] && (io_rd || io_wr) && io_addr[15:3] == m_base[d][15:3];
    return r;
  endfunction

  function automatic logic [15:0] exp_irq();
    logic [15:0] r = 0;
    for (int d = 0; d < 3; d++)
      if (m_act[d] && dev_irq[d] && (int'(m_irq[d]) inside {3, 4, 5, 6, 7, 9, 10, 11, 12, 15}))
        r[m_irq[d]] = 1'b1;
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_kc = 0; m_bitp = 0; m_ldn = 0; m_idx = 0; m_csn = 0; m_half = 0; m_saw = 0;
      for (int d = 0; d < 3; d++) begin m_base[d] = 0; m_irq[d] = 0; m_act[d] = 0; end
    end else if (m_st == 0) begin
      if (io_wr && io_addr == IDXP) begin
        if (io_wdata == key[m_kc]) m_kc++;
        else m_kc = 0;
        if (m_kc == 32) begin m_st = 1; m_kc = 0; end
      end
    end else if (io_wr && io_addr == IDXP) m_idx = io_wdata;
    else if (io_wr && io_addr == WRP) begin
      if (m_idx == 8'h02 && io_wdata[1]) m_st = 0;
      else if (m_idx == 8'h03) begin
        if (io_wdata == m_csn) begin
          m_st = (m_csn == 0) ? 2 : 3; m_bitp = 0; m_half = 0; m_saw = 0;
        end else m_st = 1;
      end else if (m_idx == 8'h06 && m_st >= 2) begin m_csn = io_wdata; m_st = 3; end
      else if (m_st == 3) begin
        if (m_idx == 8'h07 && io_wdata < 3) m_ldn = int'(io_wdata);
        if (m_idx == 8'h30) m_act[m_ldn] = io_wdata[0];
        if (m_idx == 8'h60) m_base[m_ldn][15:8] = io_wdata;
        if (m_idx == 8'h61) m_base[m_ldn][7:0] = io_wdata;
        if (m_idx == 8'h70) m_irq[m_ldn] = io_wdata[3:0];
      end
    end else if (m_st == 2 && m_idx == 8'h01 && rd_port() && m_bitp < 72) begin
      if (!m_half) begin m_saw = io_bus == 8'h55; m_half = 1; end
      else begin
        m_half = 0;
        if (!ID[m_bitp] && m_saw && io_bus == 8'hAA) m_st = 1;
        m_bitp++;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #8;
    chk("R11 oe", int'(io_rdata_oe), int'(exp_oe()));
    if (exp_oe()) chk("R11 rdata", int'(io_rdata), int'(exp_data()));
    chk("R8 cs", int'(dev_cs), int'(exp_cs()));
    chk("R9 irq", int'(irq_line), int'(exp_irq()));
  end

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); io_wr = 1; io_addr = a; io_wdata = d;
    @(negedge clk); io_wr = 0;
  endtask

  task automatic io_read(input logic [15:0] a, output logic [7:0] d, output logic oe);
    @(negedge clk); io_rd = 1; io_addr = a;
    #6; d = io_rdata; oe = io_rdata_oe;
    @(negedge clk); io_rd = 0;
  endtask

  task automatic io_touch(input logic [15:0] a, output logic [2:0] cs);
    @(negedge clk); io_wr = 1; io_addr = a; io_wdata = 8'h00;
    #6; cs = dev_cs;
    @(negedge clk); io_wr = 0;
  endtask

  task automatic setreg(input logic [7:0] idx, input logic [7:0] v);
    io_write(IDXP, idx); io_write(WRP, v);
  endtask

  task automatic send_key(input int from, input int upto);
    for (int i = from; i < upto; i++) io_write(IDXP, key[i]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic oe;
    logic [2:0] cs;
    key[0] = 8'h6A;
    for (int i = 1; i < 32; i++) key[i] = {key[i-1][1] ^ key[i-1][0], key[i-1][7:1]};
    dev_irq = 3'b111;
    repeat (2) @(negedge clk);
    #6;
    chk("R1 oe", int'(io_rdata_oe), 0);
    chk("R1 cs", int'(dev_cs), 0);
    chk("R1 irq", int'(irq_line), 0);
    @(negedge clk); rst_n = 1;

    // R2: wake and reads before the key do nothing
    setreg(8'h03, 8'h00);
    io_read(RDP, d, oe); chk("R2 locked read", int'(oe), 0);
    // R2: a wrong byte mid-key restarts matching
    send_key(0, 10); io_write(IDXP, 8'h00); send_key(10, 32);
    setreg(8'h03, 8'h00); io_write(IDXP, 8'h01);
    io_read(RDP, d, oe); chk("R2 broken key", int'(oe), 0);
    send_key(0, 32);
    // R3: wake 0 with CSN 0 enters isolation
    setreg(8'h03, 8'h00); io_write(IDXP, 8'h01);
    for (int b = 0; b < 4; b++) begin
      io_read(RDP, d, oe); chk("R4 first", int'({oe, d}), int'({1'b1, 8'h55}));
      io_read(RDP, d, oe); chk("R4 second", int'({oe, d}), int'({1'b1, 8'hAA}));
    end
    // R5: bit 4 is 0 and a rival drives the pattern
    rival_on = 1; rival_val = 8'h55;
    io_read(RDP, d, oe); chk("R5 silent", int'(oe), 0);
    rival_val = 8'hAA;
    io_read(RDP, d, oe); chk("R5 silent", int'(oe), 0);
    rival_on = 0;
    io_read(RDP, d, oe); chk("R5 asleep", int'(oe), 0);
    // R3: wake again from sleep and win a full round
    setreg(8'h03, 8'h00); io_write(IDXP, 8'h01);
    for (int b = 0; b < 72; b++) begin
      io_read(RDP, d, oe);
      chk("R4 bit first", int'({oe, oe ? d : 8'h00}), ID[b] ? int'({1'b1, 8'h55}) : 0);
      io_read(RDP, d, oe);
      chk("R4 bit second", int'({oe, oe ? d : 8'h00}), ID[b] ? int'({1'b1, 8'hAA}) : 0);
    end
    io_read(RDP, d, oe); chk("R4 past end", int'(oe), 0);
    // R6
    setreg(8'h06, 8'h01);
    io_read(RDP, d, oe); chk("R6 csn", int'({oe, d}), int'({1'b1, 8'h01}));
    // R7: program three banks
    setreg(8'h07, 8'h00); setreg(8'h60, 8'h03); setreg(8'h61, 8'hF8); setreg(8'h70, 8'h04);
    setreg(8'h07, 8'h01); setreg(8'h60, 8'h82); setreg(8'h61, 8'hF8); setreg(8'h70, 8'h0F);
    setreg(8'h07, 8'h02); setreg(8'h60, 8'h03); setreg(8'h61, 8'h78); setreg(8'h70, 8'h08);
    setreg(8'h07, 8'h03);
    io_read(RDP, d, oe); chk("R7 ldn ignore", int'(d), 2);
    setreg(8'h07, 8'h00); io_write(IDXP, 8'h60);
    io_read(RDP, d, oe); chk("R7 bank0 hi", int'(d), 8'h03);
    setreg(8'h07, 8'h01); io_write(IDXP, 8'h60);
    io_read(RDP, d, oe); chk("R7 bank1 hi", int'(d), 8'h82);
    io_write(IDXP, 8'h70);
    io_read(RDP, d, oe); chk("R7 bank1 irq", int'(d), 8'h0F);
    io_write(IDXP, 8'h99);
    io_read(RDP, d, oe); chk("R11 unknown idx", int'({oe, d}), int'({1'b1, 8'h00}));
    io_read(16'h020C, d, oe); chk("R11 other addr", int'(oe), 0);
    // R8: inactive devices never select
    io_touch(16'h03F8, cs); chk("R8 inactive", int'(cs), 0);
    chk("R9 inactive", int'(irq_line), 0);
    for (int k = 0; k < 3; k++) begin setreg(8'h07, 8'(k)); setreg(8'h30, 8'h01); end
    io_touch(16'h03F8, cs); chk("R8 dev0", int'(cs), 3'b001);
    io_touch(16'h83F8, cs); chk("R8 a15", int'(cs), 3'b000);
    io_touch(16'h82FF, cs); chk("R8 dev1 top", int'(cs), 3'b010);
    io_touch(16'h8300, cs); chk("R8 dev1 past", int'(cs), 3'b000);
    io_touch(16'h037A, cs); chk("R8 dev2", int'(cs), 3'b100);
    @(negedge clk); #6; chk("R9 route", int'(irq_line), 16'h8010);
    dev_irq = 3'b010;
    @(negedge clk); #6; chk("R9 one", int'(irq_line), 16'h8000);
    dev_irq = 3'b111;
    setreg(8'h07, 8'h02); setreg(8'h70, 8'h1C);
    @(negedge clk); #6; chk("R9 irq12", int'(irq_line), 16'h9010);
    // R10: relock, writes ignored, settings kept
    setreg(8'h02, 8'h02);
    io_write(IDXP, 8'h60); io_write(WRP, 8'h55);
    io_read(RDP, d, oe); chk("R10 locked read", int'(oe), 0);
    io_touch(16'h03F8, cs); chk("R10 kept cs", int'(cs), 3'b001);
    send_key(0, 32);
    setreg(8'h03, 8'h05);
    io_read(RDP, d, oe); chk("R3 wrong csn", int'(oe), 0);
    setreg(8'h03, 8'h00);
    io_read(RDP, d, oe); chk("R3 zero wake csn1", int'(oe), 0);
    setreg(8'h03, 8'h01); io_write(IDXP, 8'h60);
    io_read(RDP, d, oe); chk("R10 unchanged", int'({oe, d}), int'({1'b1, 8'h03}));
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule